// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bit Transmitter

This block is the host end of a one-wire, open-drain serial link. Each bit travels in its own frame. The host opens a frame by pulling the shared line low. It keeps the line low for a short time to send a one, or for a longer time to send a zero, and then lets go. An external pull-up brings the line back high after release. The block only ever asserts a drive-low enable toward the open-drain pad and never drives the line high. A zero frame also acts as an acknowledge, and a one frame also acts as a no-acknowledge.

Bits come in through a valid/ready handshake. Three runtime cycle counts set the timing: the short low time, the long low time and the total frame period. The block takes a snapshot of the bit and all three counts when it accepts a bit. After release it waits out the remainder of the period, so consecutive frames never overlap. It marks the final cycle of every frame with a one-cycle done strobe.

Top module: `sw_bit_tx`

## Requirements
- R1: A bit is accepted at a rising clock edge where `bitValid` and `bitReady` are both 1, and `driveLow` is 1 in the very next cycle, which is cycle 0 of the frame.
- R2: When the accepted `bitData` is 1, `driveLow` stays 1 for exactly `shortLow` consecutive cycles (frame cycles 0 to `shortLow`-1) and is 0 for the rest of the frame.
- R3: When the accepted `bitData` is 0 (also used as acknowledge), `driveLow` stays 1 for exactly `longLow` consecutive cycles and is 0 for the rest of the frame.
- R4: A frame lasts exactly `framePeriod` cycles counted from its first low cycle. `frameDone` is 1 only in the last cycle of the frame (cycle `framePeriod`-1), for one cycle.
- R5: `bitReady` is 0 for the whole frame. A `bitValid` held at 1 during a frame, even with a different bit, starts no frame and does not alter the frame in progress.
- R6: `bitReady` is 1 in the cycle after `frameDone`, and a bit offered in that cycle starts the next frame with no idle gap.
- R7: The bit value and the three counts are sampled at acceptance. Changing `shortLow`, `longLow`, `framePeriod` or `bitData` during a frame has no effect on that frame.
- R8: A synchronous `rst` seen at a clock edge releases the line in the following cycle (`driveLow` 0, `frameDone` 0, `bitReady` 1), even in the middle of a frame.
- R9: After reset the block is idle: `bitReady` 1, `driveLow` 0, `frameDone` 0.
- R10: The counts must satisfy 1 <= `shortLow` < `longLow` < `framePeriod`. The block drives only an active-high drive-low enable, never a high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | A bit is offered |
| bitData | input | 1 | Bit to send (1 = short low, 0 = long low) |
| bitReady | output | 1 | Block is idle and can accept a bit |
| shortLow | input | CNT_W | Low time in cycles for a one |
| longLow | input | CNT_W | Low time in cycles for a zero |
| framePeriod | input | CNT_W | Total frame length in cycles |
| driveLow | output | 1 | Enable for the open-drain pull-down |
| frameDone | output | 1 | One-cycle strobe in the last frame cycle |

## Verification
The bench sends a one and a zero with the same timing counts, which shows that only the low width depends on the bit. It also runs the smallest legal counts (1, 2, 3), a period just one cycle longer than the long low time, and a wide period. Other patterns hold `bitValid` at 1 with the opposite bit through a frame, rewrite every count in the middle of a frame, and chain frames back to back. These separate a correct snapshot and busy handshake from designs that re-sample their inputs or accept a bit early. A reset issued while the line is low confirms that the line is released at once.

// File: rtl/sw_bit_tx_pkg.sv
package sw_bit_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_REST = 2'd2
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture bit and counts, clear the cycle counter
    logic run;   // advance the cycle counter
  } dpStrobe_t;

endpackage

// File: rtl/sw_bit_tx_dp.sv
module sw_bit_tx_dp
  import sw_bit_tx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  input  logic             bitData,
  input  logic [CNT_W-1:0] shortLow,
  input  logic [CNT_W-1:0] longLow,
  input  logic [CNT_W-1:0] framePeriod,
  output logic             lowEnd,
  output logic             frameEnd
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cycleCnt;
  logic [CNT_W-1:0] lowLen;
  logic [CNT_W-1:0] perLen;
  logic [EXT_W-1:0] cntNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycleCnt <= '0;
      lowLen   <= '0;
      perLen   <= '0;
    end else if (strobe.load) begin
      cycleCnt <= '0;
      lowLen   <= bitData ? shortLow : longLow;
      perLen   <= framePeriod;
    end else if (strobe.run) begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  // compare one ahead so the last cycle of each phase is flagged without underflow
  assign cntNext  = {1'b0, cycleCnt} + EXT_W'(1);
  assign lowEnd   = (cntNext == {1'b0, lowLen});
  assign frameEnd = (cntNext == {1'b0, perLen});

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe.run && !strobe.load |=> cycleCnt == $past(cycleCnt) + 1'b1); // R4

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(lowLen) && $stable(perLen)); // R7

endmodule

// File: rtl/sw_bit_tx_ctrl.sv
module sw_bit_tx_ctrl
  import sw_bit_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      bitValid,
  input  logic      lowEnd,
  input  logic      frameEnd,
  output logic      bitReady,
  output logic      driveLow,
  output logic      frameDone,
  output dpStrobe_t strobe
);

  txState_t state;
  txState_t stateNext;

  assign bitReady     = (state == ST_IDLE);
  assign driveLow     = (state == ST_LOW);
  assign frameDone    = (state != ST_IDLE) && frameEnd;
  assign strobe.load  = bitValid && bitReady;
  assign strobe.run   = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strobe.load) stateNext = ST_LOW;
      ST_LOW:  if (lowEnd)      stateNext = frameEnd ? ST_IDLE : ST_REST;
      ST_REST: if (frameEnd)    stateNext = ST_IDLE;
      default:                  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  AST_ACCEPT_LOW: assert property (@(posedge clk) disable iff (rst)
    bitValid && bitReady |=> driveLow); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> !frameDone); // R4

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> bitReady); // R6

  AST_NO_BUSY_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    bitValid && !bitReady && !frameDone |=> !bitReady); // R5

  AST_RESET_RELEASE: assert property (@(posedge clk)
    rst |=> !driveLow && bitReady && !frameDone); // R8

endmodule

// File: rtl/sw_bit_tx.sv
module sw_bit_tx
  import sw_bit_tx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitValid,
  input  logic             bitData,
  output logic             bitReady,
  input  logic [CNT_W-1:0] shortLow,
  input  logic [CNT_W-1:0] longLow,
  input  logic [CNT_W-1:0] framePeriod,
  output logic             driveLow,
  output logic             frameDone
);

  dpStrobe_t strobe;
  logic      lowEnd;
  logic      frameEnd;

  sw_bit_tx_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bitValid  (bitValid),
    .lowEnd    (lowEnd),
    .frameEnd  (frameEnd),
    .bitReady  (bitReady),
    .driveLow  (driveLow),
    .frameDone (frameDone),
    .strobe    (strobe)
  );

  sw_bit_tx_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .bitData     (bitData),
    .shortLow    (shortLow),
    .longLow     (longLow),
    .framePeriod (framePeriod),
    .lowEnd      (lowEnd),
    .frameEnd    (frameEnd)
  );

endmodule

// File: tb/sw_bit_tx_bench.sv
module sw_bit_tx_bench;

  localparam int CNT_W = 16;
  localparam int NVEC  = 6;

  // vector: {bit, shortLow[7:0], longLow[7:0], framePeriod[7:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 8'd2, 8'd5,  8'd8},
    {1'b0, 8'd2, 8'd5,  8'd8},
    {1'b1, 8'd1, 8'd2,  8'd3},
    {1'b0, 8'd1, 8'd2,  8'd3},
    {1'b1, 8'd3, 8'd9,  8'd10},
    {1'b0, 8'd4, 8'd12, 8'd20}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitValid = 1'b0;
  logic bitData = 1'b0;
  logic bitReady;
  logic [CNT_W-1:0] shortLow = '0;
  logic [CNT_W-1:0] longLow = '0;
  logic [CNT_W-1:0] framePeriod = '0;
  logic driveLow;
  logic frameDone;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sw_bit_tx #(.CNT_W(CNT_W)) u_sw_bit_tx (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitData(bitData),
    .bitReady(bitReady), .shortLow(shortLow), .longLow(longLow),
    .framePeriod(framePeriod), .driveLow(driveLow), .frameDone(frameDone)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Send one bit from idle; caller is at a negedge. Returns at the negedge of cycle P.
  task automatic sendBit(input bit b, input int s, input int l, input int p,
                         input bit holdValid, input bit changeCfg, input string tagLow);
    int expLow = b ? s : l;
    int lowBad = -1, doneBad = -1, readyBad = -1;
    int lowSeen = 0;
    shortLow = CNT_W'(s); longLow = CNT_W'(l); framePeriod = CNT_W'(p);
    bitData = b; bitValid = 1'b1;
    @(negedge clk);
    check(driveLow === 1'b1, "R1", "driveLow in cycle 0", int'(driveLow), 1);
    if (holdValid) bitData = ~b; else bitValid = 1'b0;
    if (changeCfg) begin
      bitData = ~b; shortLow = CNT_W'(l + 3); longLow = CNT_W'(l + 7);
      framePeriod = CNT_W'(p + 9);
    end
    for (int c = 0; c <= p; c++) begin
      if (c > 0) @(negedge clk);
      if (driveLow) lowSeen++;
      if (driveLow !== (c < expLow) && lowBad < 0) lowBad = c;
      if (frameDone !== (c == p - 1) && doneBad < 0) doneBad = c;
      if (bitReady !== (c == p) && readyBad < 0) readyBad = c;
    end
    bitValid = 1'b0;
    check(lowBad < 0 && lowSeen == expLow, tagLow, "low width", lowSeen, expLow);
    check(doneBad < 0, "R4", "frameDone cycle (first bad cycle)", doneBad, -1);
    check(readyBad < 0, holdValid ? "R5" : "R6", "bitReady shape (first bad cycle)",
          readyBad, -1);
    shortLow = CNT_W'(s); longLow = CNT_W'(l); framePeriod = CNT_W'(p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: idle after reset
    check(bitReady === 1'b1 && driveLow === 1'b0 && frameDone === 1'b0, "R9",
          "idle outputs {ready,low,done}", {bitReady, driveLow, frameDone}, 3'b100);

    // vector table: R2 for ones, R3 for zeros
    for (int i = 0; i < NVEC; i++) begin
      sendBit(VEC[i][24], int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]),
              1'b0, 1'b0, VEC[i][24] ? "R2" : "R3");
    end
    // the loop chained frames back to back (R6); now let the block idle one cycle
    @(negedge clk);

    // R5: valid held with opposite bit during a frame
    sendBit(1'b1, 2, 6, 9, 1'b1, 1'b0, "R5");
    @(negedge clk);
    check(driveLow === 1'b0, "R5", "no frame from held valid", int'(driveLow), 0);

    // R7: config and bit rewritten mid-frame
    sendBit(1'b0, 3, 7, 11, 1'b0, 1'b1, "R7");
    @(negedge clk);

    // R8: reset in the middle of the low phase
    shortLow = 16'd2; longLow = 16'd10; framePeriod = 16'd16;
    bitData = 1'b0; bitValid = 1'b1;
    @(negedge clk);
    bitValid = 1'b0;
    repeat (3) @(negedge clk);
    check(driveLow === 1'b1, "R8", "line low before reset", int'(driveLow), 1);
    rst = 1'b1;
    @(negedge clk);
    check(driveLow === 1'b0 && bitReady === 1'b1 && frameDone === 1'b0, "R8",
          "released after reset {ready,low,done}", {bitReady, driveLow, frameDone}, 3'b100);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(driveLow === 1'b0 && frameDone === 1'b0, "R8", "stays idle after reset",
          {driveLow, frameDone}, 0);

    // R10: minimum legal counts after recovery
    sendBit(1'b1, 1, 2, 3, 1'b0, 1'b0, "R10");

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule